// File: doc/BRIEF.md
# Two-Smallest Selection Network

This block takes a set of N unsigned M-bit items, presented together on one wide input bus, and reports the smallest item and the next smallest item of that set. N is a power of two, N = 2^L. The selection is done by a network of compare-and-swap cells, with no sorting and no sequencing. A first network of L levels moves the minimum onto the last line and leaves every other item, unordered, on the remaining lines. A second reduction tree, also L levels deep, then finds the minimum of those N-1 leftover lines.

The two networks use 2N-3 comparators in total. Level i of the first network holds N/2^(i+1) cells, each working on its own pair of lines. The second network holds N-2 cells. Both results can be captured in output registers, chosen by a parameter, so that the long compare path ends in a flop.

Typical users are check-node units in min-sum decoders and any datapath that needs both the best and the runner-up value in one pass.

Top module: `two_min_net`

## Requirements
- R1: `smallest` equals the least of the N items, where item k is taken from bits [k*M +: M] of `vals`.
- R2: `next_smallest` equals the least item left once a single copy of the minimum has been removed. If the minimum value occurs two or more times, `next_smallest` therefore equals `smallest`.
- R3: All comparisons are unsigned. An item with its top bit set ranks above every item whose top bit is clear.
- R4: Each compare-and-swap cell exchanges its two lines when the upper line holds the smaller value, and passes both through unchanged otherwise. The first network therefore only permutes the items: their sum is preserved, and the last line ends up holding the minimum.
- R5: With OUT_REG=1, both outputs change only at a rising clock edge and show the result for the `vals` present before that edge (a latency of one cycle).
- R6: While `rst_n` is low (OUT_REG=1), both outputs read zero.
- R7: `smallest` is never greater than `next_smallest`.
- R8: When all N items are equal, both outputs equal that value.
- R9: The result does not depend on where the two smallest items sit in the bus, including the first and the last item positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output registers |
| rst_n | input | 1 | Active-low reset of the output registers |
| vals | input | N*M | Packed items; item k occupies bits [k*M +: M] |
| smallest | output | M | Least item of the set |
| next_smallest | output | M | Second least item, with duplicates counted |

## Verification
Sets with duplicates matter most. A second-stage search that skipped every line equal to the minimum, instead of skipping only the one line the minimum came from, would report a larger runner-up whenever the minimum appears twice. Placing the minimum at each position in turn, including the first and the last item, exposes an index error in the per-level pairing. Such an error leaves one line out of a level, so the result goes wrong only for some positions. Items with the top bit set catch a signed comparison, which would rank them as the smallest. Changing the inputs just before a clock edge shows whether the outputs really wait for that edge.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  localparam int TSM_WMAX = 64;

  // True when the upper line holds the strictly smaller unsigned value.
  function automatic logic tsm_upper_less(input logic [TSM_WMAX-1:0] up,
                                          input logic [TSM_WMAX-1:0] dn);
    return up < dn;
  endfunction

  // Live line count at level t of a halving reduction that starts with k0 lines.
  function automatic int tsm_lines_at(input int k0, input int t);
    int c;
    c = k0;
    for (int s = 0; s < t; s++) c = (c + 1) / 2;
    return c;
  endfunction

  // Comparators used by both networks together.
  function automatic int tsm_cell_total(input int n);
    return 2 * n - 3;
  endfunction

endpackage

// File: rtl/tsm_cas.sv
module tsm_cas #(
  parameter int M = 8
) (
  input  logic [M-1:0] up_i,
  input  logic [M-1:0] dn_i,
  output logic [M-1:0] up_o,
  output logic [M-1:0] dn_o
);
  logic swap;
  assign swap = tsm_pkg::tsm_upper_less(tsm_pkg::TSM_WMAX'(up_i), tsm_pkg::TSM_WMAX'(dn_i));
  assign dn_o = swap ? up_i : dn_i;
  assign up_o = swap ? dn_i : up_i;
endmodule

// File: rtl/tsm_pick.sv
module tsm_pick #(
  parameter int M = 8
) (
  input  logic [M-1:0] up_i,
  input  logic [M-1:0] dn_i,
  output logic [M-1:0] min_o
);
  assign min_o = tsm_pkg::tsm_upper_less(tsm_pkg::TSM_WMAX'(up_i), tsm_pkg::TSM_WMAX'(dn_i))
                 ? up_i : dn_i;
endmodule

// File: rtl/tsm_first_net.sv
module tsm_first_net #(
  parameter int N = 8,
  parameter int M = 8
) (
  input  logic [N*M-1:0] vals_i,
  output logic [N*M-1:0] lines_o
);
  localparam int L = $clog2(N);

  logic [M-1:0] f [L+1][N];

  for (genvar n = 0; n < N; n++) begin : g_load
    assign f[0][n] = vals_i[n*M +: M];
    assign lines_o[n*M +: M] = f[L][n];
  end

  for (genvar i = 0; i < L; i++) begin : g_lvl
    localparam int HALF = 1 << i;
    localparam int STEP = HALF * 2;
    for (genvar n = 0; n < N; n++) begin : g_line
      localparam int D = N - 1 - n;
      if (D % STEP == 0) begin : g_cell
        tsm_cas #(.M(M)) u_cas (
          .up_i (f[i][n-HALF]),
          .dn_i (f[i][n]),
          .up_o (f[i+1][n-HALF]),
          .dn_o (f[i+1][n])
        );
      end else if (D % STEP != HALF) begin : g_pass
        assign f[i+1][n] = f[i][n];
      end
    end
  end
endmodule

// File: rtl/tsm_second_net.sv
module tsm_second_net #(
  parameter int K  = 7,
  parameter int LV = 3,
  parameter int M  = 8
) (
  input  logic [K*M-1:0] lines_i,
  output logic [M-1:0]   min_o
);
  logic [M-1:0] s [LV+1][K];

  for (genvar k = 0; k < K; k++) begin : g_load
    assign s[0][k] = lines_i[k*M +: M];
  end

  for (genvar t = 0; t < LV; t++) begin : g_lvl
    localparam int CNT  = tsm_pkg::tsm_lines_at(K, t);
    localparam int NEXT = tsm_pkg::tsm_lines_at(K, t + 1);
    for (genvar k = 0; k < K; k++) begin : g_slot
      if (k < NEXT && 2*k + 1 < CNT) begin : g_cell
        tsm_pick #(.M(M)) u_pick (
          .up_i  (s[t][2*k]),
          .dn_i  (s[t][2*k+1]),
          .min_o (s[t+1][k])
        );
      end else if (k < NEXT) begin : g_pass
        assign s[t+1][k] = s[t][2*k];
      end else begin : g_idle
        assign s[t+1][k] = s[t][k];
      end
    end
  end

  assign min_o = s[LV][0];
endmodule

// File: rtl/two_min_net.sv
module two_min_net #(
  parameter int N       = 8,
  parameter int M       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*M-1:0] vals,
  output logic [M-1:0]   smallest,
  output logic [M-1:0]   next_smallest
);
  localparam int L  = $clog2(N);
  localparam int K  = N - 1;
  localparam int SW = M + L;

  // Named internal events for the checks below.
  logic [N*M-1:0] first_bus;
  logic [K*M-1:0] rest_bus;
  logic [M-1:0]   floor_line;
  logic [M-1:0]   runner_line;
  logic [SW-1:0]  in_sum;
  logic [SW-1:0]  net_sum;

  tsm_first_net #(.N(N), .M(M)) u_first (
    .vals_i  (vals),
    .lines_o (first_bus)
  );

  assign rest_bus   = first_bus[K*M-1:0];
  assign floor_line = first_bus[K*M +: M];

  tsm_second_net #(.K(K), .LV(L), .M(M)) u_second (
    .lines_i (rest_bus),
    .min_o   (runner_line)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smallest      <= '0;
        next_smallest <= '0;
      end else begin
        smallest      <= floor_line;
        next_smallest <= runner_line;
      end
    end
  end else begin : g_comb
    assign smallest      = floor_line;
    assign next_smallest = runner_line;
  end

  always_comb begin
    in_sum  = '0;
    net_sum = '0;
    for (int k = 0; k < N; k++) begin
      in_sum  = in_sum  + SW'(vals[k*M +: M]);
      net_sum = net_sum + SW'(first_bus[k*M +: M]);
    end
  end

  // R4: the first network only permutes its items
  assert_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_sum == net_sum);

  for (genvar n = 0; n < K; n++) begin : g_chk
    // R1: the last line of the first network is the floor of all lines
    assert_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
      floor_line <= first_bus[n*M +: M]);
    // R2: the runner-up is the floor of the leftover lines
    assert_runner_R2: assert property (@(posedge clk) disable iff (!rst_n)
      runner_line <= rest_bus[n*M +: M]);
  end

  // R7: ordering of the two results at the ports
  assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smallest <= next_smallest);

  // R2: the runner-up is never below the leftover floor of the first network
  assert_rank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    floor_line <= runner_line);
endmodule

// File: tb/two_min_net_tb.sv
module two_min_net_tb;
  localparam int M  = 8;
  localparam int NA = 8;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB*M-1:0] vec = '0;
  logic [M-1:0] a_min, a_nxt, b_min, b_nxt;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  two_min_net #(.N(NA), .M(M), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .vals(vec[NA*M-1:0]),
    .smallest(a_min), .next_smallest(a_nxt));

  two_min_net #(.N(NB), .M(M), .OUT_REG(1'b1)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .vals(vec),
    .smallest(b_min), .next_smallest(b_nxt));

  task automatic chk(input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Linear-scan reference over the first cnt items.
  task automatic ref2(input logic [NB*M-1:0] v, input int cnt,
                      output logic [M-1:0] m1, output logic [M-1:0] m2);
    m1 = '1; m2 = '1;
    for (int k = 0; k < cnt; k++) begin
      logic [M-1:0] x;
      x = v[k*M +: M];
      if (x < m1) begin m2 = m1; m1 = x; end
      else if (x < m2) m2 = x;
    end
  endtask

  task automatic verify(input string tag);
    logic [M-1:0] e1, e2;
    ref2(vec, NA, e1, e2);
    chk({tag, " R1 n8 smallest"}, a_min, e1);
    chk({tag, " R2 n8 runner"}, a_nxt, e2);
    ref2(vec, NB, e1, e2);
    chk({tag, " R1 n16 smallest"}, b_min, e1);
    chk({tag, " R2 n16 runner"}, b_nxt, e2);
    n_chk++;
    if (a_min > a_nxt || b_min > b_nxt) begin
      n_bad++;
      $display("FAIL R7 order actual=%0h/%0h %0h/%0h expected ascending", a_min, a_nxt, b_min, b_nxt);
    end
  endtask

  task automatic apply(input logic [NB*M-1:0] v, input string tag);
    @(negedge clk) vec = v;
    @(negedge clk) verify(tag);
  endtask

  task automatic t_reset();
    vec = {NB{8'h3c}};
    repeat (3) @(negedge clk);
    chk("R6 reset n8 smallest", a_min, '0);
    chk("R6 reset n8 runner", a_nxt, '0);
    chk("R6 reset n16 smallest", b_min, '0);
    chk("R6 reset n16 runner", b_nxt, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_random();
    for (int r = 0; r < 40; r++) begin
      logic [NB*M-1:0] v;
      for (int k = 0; k < NB; k++) v[k*M +: M] = M'($urandom);
      apply(v, "random");
    end
  endtask

  task automatic t_dups();
    for (int r = 0; r < 30; r++) begin
      logic [NB*M-1:0] v;
      for (int k = 0; k < NB; k++) v[k*M +: M] = M'($urandom % 4);
      apply(v, "dups R2");
    end
    apply({NB{8'ha5}}, "R8 all equal");
    apply({NB{8'hff}}, "R8 all max");
    apply({NB{8'h00}}, "R8 all zero");
  endtask

  task automatic t_position();
    for (int p = 0; p < NB; p++) begin
      logic [NB*M-1:0] v;
      v = {NB{8'hf0}};
      v[p*M +: M] = 8'h11;
      v[((p + 5) % NB)*M +: M] = 8'h22;
      v[((p + 3) % NA)*M +: M] = 8'h33;
      apply(v, "R9 position");
    end
  endtask

  task automatic t_unsigned();
    logic [NB*M-1:0] v;
    v = {NB{8'hc0}};
    v[2*M +: M] = 8'h7f;
    v[6*M +: M] = 8'h80;
    v[12*M +: M] = 8'hff;
    apply(v, "R3 unsigned");
    for (int k = 0; k < NB; k++) v[k*M +: M] = 8'h80 | M'($urandom);
    apply(v, "R3 top bit set");
  endtask

  task automatic t_latency();
    logic [NB*M-1:0] v;
    v = {NB{8'h40}};
    v[1*M +: M] = 8'h05;
    v[4*M +: M] = 8'h09;
    apply(v, "R5 setup");
    @(negedge clk) vec = {NB{8'h01}};
    #2;
    chk("R5 hold n8 smallest", a_min, 8'h05);
    chk("R5 hold n16 runner", b_nxt, 8'h09);
    @(negedge clk);
    chk("R5 update n8 smallest", a_min, 8'h01);
    chk("R5 update n16 runner", b_nxt, 8'h01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_random();
    t_dups();
    t_position();
    t_unsigned();
    t_latency();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule